// File: doc/BRIEF.md
# Dot-Matrix Column Driver Controller

This block models one column-driver slice of a dot-matrix display. It keeps a display memory of four pages by fifty columns of bytes and is reached from a host through a small bus. A register-select input chooses between the command/status location and the data location. Commands set the page and column, pick the page the scan begins on, set the direction of the column counter, and turn the display on or off. Each data read or data write goes to the addressed byte and then moves the column by one place.

A chip-select input lets several slices share one host bus. After each accepted command or data access, the block reports busy for a fixed number of clocks. Anything other than a status read is dropped during that time. A scan port takes a scan slot and a column and returns the byte the panel would show there. The slot is mapped to a page by rotating from the start page. The scan byte is zero while the display is off.

Top module: `lcd_col_ctrl`

## Requirements
- R1: A command write (rs=0) whose bits 5:0 are below 50 sets the page to bits 7:6 and the column to bits 5:0.
- R2: A data write (rs=1) stores din at the current page and column, and the column then steps one place.
- R3: A data read (rs=1, rd=1) puts the byte at the current page and column on dout at the next clock edge, and the column then steps one place.
- R4: Command code 61 in bits 5:0 sets the counter direction from bit 7, where 1 is up and 0 is down. The direction is up after reset.
- R5: Counting up, the column wraps from 49 to 0. Counting down, it wraps from 0 to 49. The page never changes on a step.
- R6: Command code 60 in bits 5:0 sets the start page from bits 7:6. Scan slot s then shows page (start+s) mod 4.
- R7: Command code 62 in bits 5:0 turns the display on when bit 7 is 1 and off when it is 0. While the display is off, scan_data is 0 and memory keeps its contents. The display is off after reset.
- R8: A status read (rs=0, rd=1) puts busy in bit 7, direction in bit 6 and display-on in bit 5 on dout at the next edge, with bits 4:0 zero. A status read is served even while busy.
- R9: After each accepted command or data access, busy stays high for BUSY_CYC clocks. Command and data accesses made while busy are ignored.
- R10: While cs is 0, all accesses are ignored.
- R11: After reset, the page, column and start page are 0, dout is 0, busy is low and memory is all zero.
- R12: A command whose bits 5:0 are 50 to 59 or 63 changes no address, mode or memory state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rs | input | 1 | Register select: 0 command/status, 1 data |
| wr | input | 1 | Write strobe, one clock per access |
| rd | input | 1 | Read strobe, one clock per access |
| din | input | 8 | Host write data |
| dout | output | 8 | Registered read data or status |
| scan_slot | input | 2 | Scan slot index |
| scan_col | input | 6 | Scan column |
| scan_data | output | 8 | Byte shown at the scan position, 0 when the display is off |

## Verification
Writes and reads are run with the counter going up and going down, from a column in the middle and from each end of the range. This separates a correct step from a missing step, a step in the wrong direction, and a bad wrap. The start page is set to 0, 1 and 3 and checked on several slots, which exposes a rotation that is wrong or missing. Second accesses issued inside the busy window, accesses with chip select low, and unused command codes are each followed by a read-back, so any of them that leaks into state is seen at the ports.

// File: rtl/lcd_col_pkg.sv
// Package: command codes and shared sizes for the column driver controller.
// Assumes the column count stays below the lowest command code (60).
package lcd_col_pkg;
    localparam logic [5:0] CMD_START = 6'd60;
    localparam logic [5:0] CMD_DIR   = 6'd61;
    localparam logic [5:0] CMD_DISP  = 6'd62;
endpackage

// File: rtl/lcd_busy_timer.sv
// Busy timer: loads BUSY_CYC on start and counts down to zero.
// Assumes start is only raised while the timer is idle.
module lcd_busy_timer #(
    parameter int BUSY_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    logic [CW-1:0] cnt;

    // load on start, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(BUSY_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    assert_busy_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_busy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(BUSY_CYC));
endmodule

// File: rtl/lcd_addr_ctr.sv
// Page/column address counter. Loads from a command and steps the column
// up or down with wrap. Assumes load and step are never high together.
module lcd_addr_ctr #(
    parameter int PAGES = 4,
    parameter int COLS  = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [$clog2(PAGES)-1:0]   load_page,
    input  logic [$clog2(COLS)-1:0]    load_col,
    input  logic                       step,
    input  logic                       up,
    output logic [$clog2(PAGES)-1:0]   page,
    output logic [$clog2(COLS)-1:0]    col
);
    localparam int PW = $clog2(PAGES);
    localparam int CW = $clog2(COLS);
    localparam logic [CW-1:0] LAST = CW'(COLS - 1);

    // address register: load, or step with wrap at both ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
        end else if (load) begin
            page <= load_page;
            col  <= load_col;
        end else if (step) begin
            if (up) col <= (col == LAST) ? '0 : col + 1'b1;
            else    col <= (col == '0) ? LAST : col - 1'b1;
        end
    end

    assert_col_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        col <= LAST);
    assert_wrap_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && up && col == LAST) |=> (col == '0 && $stable(page)));
    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !up && col == '0) |=> (col == LAST && $stable(page)));
endmodule

// File: rtl/lcd_mem_array.sv
// Display memory: one write port and two read ports, one for the host
// and one for the scan. Cleared by reset. Reads are combinational.
module lcd_mem_array #(
    parameter int PAGES = 4,
    parameter int COLS  = 50,
    parameter int DW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [$clog2(PAGES)-1:0]  h_page,
    input  logic [$clog2(COLS)-1:0]   h_col,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             h_rdata,
    input  logic [$clog2(PAGES)-1:0]  s_page,
    input  logic [$clog2(COLS)-1:0]   s_col,
    output logic [DW-1:0]             s_rdata
);
    localparam int DEPTH = PAGES * COLS;
    localparam int AW    = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] h_idx, s_idx;

    assign h_idx = AW'(h_page) * AW'(COLS) + AW'(h_col);
    assign s_idx = AW'(s_page) * AW'(COLS) + AW'(s_col);

    // storage: clear on reset, host write otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[h_idx] <= wdata;
        end
    end

    // read ports, with out-of-range scan columns giving zero
    always_comb begin
        h_rdata = mem[h_idx];
        s_rdata = (int'(s_col) < COLS) ? mem[s_idx] : '0;
    end
endmodule

// File: rtl/lcd_col_ctrl.sv
// Top of the column driver controller. Decodes host accesses, holds the
// mode state and drives the registered read port and the scan port.
// Assumes wr and rd are one-clock strobes and COLS is below 60.
module lcd_col_ctrl #(
    parameter int PAGES    = 4,
    parameter int COLS     = 50,
    parameter int BUSY_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rs,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] din,
    output logic [7:0] dout,
    input  logic [1:0] scan_slot,
    input  logic [5:0] scan_col,
    output logic [7:0] scan_data
);
    import lcd_col_pkg::*;
    localparam int PW = $clog2(PAGES);
    localparam int CW = $clog2(COLS);

    logic          busy, up_q, on_q;
    logic [PW-1:0] start_q, cur_page, scan_page;
    logic [CW-1:0] cur_col;
    logic [7:0]    mem_h, mem_s;
    logic          stat_rd, acc, cmd_wr, dat_wr, dat_rd, addr_cmd;
    logic [5:0]    code;

    assign code     = din[5:0];
    assign stat_rd  = cs && rd && !wr && !rs;
    assign acc      = cs && (wr || rd) && !busy && !stat_rd;
    assign cmd_wr   = acc && wr && !rs;
    assign dat_wr   = acc && wr && rs;
    assign dat_rd   = acc && rd && !wr && rs;
    assign addr_cmd = cmd_wr && (int'(code) < COLS);

    lcd_busy_timer #(.BUSY_CYC(BUSY_CYC)) timer_i (
        .clk(clk), .rst_n(rst_n), .start(acc), .busy(busy));

    lcd_addr_ctr #(.PAGES(PAGES), .COLS(COLS)) addr_i (
        .clk(clk), .rst_n(rst_n), .load(addr_cmd),
        .load_page(din[7:6]), .load_col(code[CW-1:0]),
        .step(dat_wr || dat_rd), .up(up_q),
        .page(cur_page), .col(cur_col));

    assign scan_page = start_q + scan_slot;

    lcd_mem_array #(.PAGES(PAGES), .COLS(COLS), .DW(8)) mem_i (
        .clk(clk), .rst_n(rst_n), .we(dat_wr),
        .h_page(cur_page), .h_col(cur_col), .wdata(din), .h_rdata(mem_h),
        .s_page(scan_page), .s_col(scan_col), .s_rdata(mem_s));

    // mode registers written by the mode commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q    <= 1'b1;
            on_q    <= 1'b0;
            start_q <= '0;
        end else if (cmd_wr) begin
            if (code == CMD_START) start_q <= din[7:6];
            if (code == CMD_DIR)   up_q    <= din[7];
            if (code == CMD_DISP)  on_q    <= din[7];
        end
    end

    // registered read data: status or memory byte
    always_ff @(posedge clk) begin
        if (!rst_n)       dout <= '0;
        else if (stat_rd) dout <= {busy, up_q, on_q, 5'b0};
        else if (dat_rd)  dout <= mem_h;
    end

    assign scan_data = on_q ? mem_s : 8'h00;

    assert_deselect_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> ($stable(cur_col) && $stable(cur_page) && $stable(dout)));
    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cur_col) && $stable(cur_page) && $stable(up_q) && $stable(on_q)));
    assert_status_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (dout[4:0] == 5'b0));
    assert_blank_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q |-> (scan_data == 8'h00));
endmodule

// File: tb/lcd_col_ctrl_tb.sv
module lcd_col_ctrl_tb_top;
    localparam int BUSY_CYC = 3;

    logic clk = 0, rst_n = 0, cs = 0, rs = 0, wr = 0, rd = 0;
    logic [7:0] din = 0;
    logic [7:0] dout, scan_data;
    logic [1:0] scan_slot = 0;
    logic [5:0] scan_col = 0;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    lcd_col_ctrl #(.PAGES(4), .COLS(50), .BUSY_CYC(BUSY_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rs(rs), .wr(wr), .rd(rd),
        .din(din), .dout(dout), .scan_slot(scan_slot), .scan_col(scan_col),
        .scan_data(scan_data));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        repeat (BUSY_CYC) @(negedge clk);
    endtask

    task automatic acc(input logic r_s, input logic w, input logic [7:0] d, input logic c);
        @(negedge clk);
        cs = c; rs = r_s; wr = w; rd = !w; din = d;
        @(negedge clk);
        cs = 0; wr = 0; rd = 0;
    endtask

    task automatic cmd(input logic [7:0] d);
        acc(1'b0, 1'b1, d, 1'b1); idle();
    endtask
    task automatic wdat(input logic [7:0] d);
        acc(1'b1, 1'b1, d, 1'b1); idle();
    endtask
    task automatic rdat(input string req, input logic [7:0] exp);
        acc(1'b1, 1'b0, 8'h00, 1'b1); chk(req, dout, exp); idle();
    endtask
    task automatic stat(input string req, input logic [7:0] exp);
        acc(1'b0, 1'b0, 8'h00, 1'b1); chk(req, dout, exp);
    endtask
    task automatic scan(input string req, input logic [1:0] s, input logic [5:0] c, input logic [7:0] exp);
        scan_slot = s; scan_col = c; #1; chk(req, scan_data, exp);
    endtask

    // R11: values right after reset
    task automatic t_reset();
        chk("R11 dout", dout, 8'h00);
        stat("R11 status up/off/idle", 8'h40);
        rdat("R11 memory clear", 8'h00);
    endtask

    // R1 R2 R3: address set, write, read back with stepping
    task automatic t_rw();
        cmd(8'h85);                     // page 2, column 5
        wdat(8'hAA); wdat(8'hBB);
        cmd(8'h85);
        rdat("R3 read first", 8'hAA);
        rdat("R2 R3 step after write", 8'hBB);
        cmd(8'hBE);                     // display on
        scan("R1 address set page2 col5", 2'd2, 6'd5, 8'hAA);
        scan("R1 address set page2 col6", 2'd2, 6'd6, 8'hBB);
    endtask

    // R5: wrap upward at column 49
    task automatic t_wrap_up();
        cmd(8'h70);                     // page 1, column 48
        wdat(8'h11); wdat(8'h22); wdat(8'h33);
        scan("R5 up col49", 2'd1, 6'd49, 8'h22);
        scan("R5 up wrap to col0", 2'd1, 6'd0, 8'h33);
        scan("R5 page unchanged", 2'd2, 6'd0, 8'h00);
    endtask

    // R4 R5: down counting with wrap at column 0
    task automatic t_down();
        cmd(8'h3D);                     // direction down
        stat("R4 status dir down", 8'h20);
        idle();
        cmd(8'hC1);                     // page 3, column 1
        wdat(8'h44); wdat(8'h55); wdat(8'h66);
        scan("R4 down col0", 2'd3, 6'd0, 8'h55);
        scan("R5 down wrap col49", 2'd3, 6'd49, 8'h66);
        cmd(8'hC0);
        rdat("R4 read down", 8'h55);
        rdat("R5 read after down wrap", 8'h66);
        cmd(8'hBD);                     // direction up again
    endtask

    // R6: start page rotation
    task automatic t_start();
        cmd(8'h7C);                     // start page 1
        scan("R6 start1 slot0", 2'd0, 6'd0, 8'h33);
        scan("R6 start1 slot3", 2'd3, 6'd5, 8'h00);
        scan("R6 start1 slot1", 2'd1, 6'd5, 8'hAA);
        cmd(8'hFC);                     // start page 3
        scan("R6 start3 slot2", 2'd2, 6'd49, 8'h22);
        scan("R6 start3 slot0", 2'd0, 6'd49, 8'h66);
        cmd(8'h3C);                     // start page 0
    endtask

    // R7: display off blanks scan, memory retained
    task automatic t_disp();
        cmd(8'h3E);
        scan("R7 off blanks", 2'd2, 6'd5, 8'h00);
        stat("R7 status off", 8'h40); idle();
        cmd(8'hBE);
        scan("R7 on again keeps data", 2'd2, 6'd5, 8'hAA);
    endtask

    // R8 R9: busy window, status while busy, ignored second write
    task automatic t_busy();
        cmd(8'h8A);                     // page 2, column 10
        @(negedge clk); cs = 1; rs = 1; wr = 1; din = 8'h5A;
        @(negedge clk); rs = 0; wr = 0; rd = 1;   // status read while busy
        @(negedge clk); cs = 0; rd = 0;
        chk("R8 status while busy", dout, 8'hE0);
        @(negedge clk); cs = 1; rs = 1; wr = 1; din = 8'hC3;  // still busy
        @(negedge clk); cs = 0; wr = 0;
        idle();
        stat("R9 busy cleared", 8'h60); idle();
        cmd(8'h8A);
        rdat("R9 first write kept", 8'h5A);
        rdat("R9 busy write ignored", 8'h00);
    endtask

    // R10: deselected accesses have no effect
    task automatic t_cs();
        cmd(8'h94);                     // page 2, column 20
        acc(1'b1, 1'b1, 8'h77, 1'b0); idle();
        acc(1'b0, 1'b1, 8'h3D, 1'b0); idle();
        stat("R10 mode unchanged", 8'h60); idle();
        rdat("R10 no write no step", 8'h00);
    endtask

    // R12: unused command codes do nothing
    task automatic t_unused();
        cmd(8'h9E);                     // page 2, column 30
        cmd(8'hF2); cmd(8'h3F);         // codes 50 and 63
        stat("R12 mode unchanged", 8'h60); idle();
        wdat(8'h9C);
        scan("R12 address unchanged", 2'd2, 6'd30, 8'h9C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_wrap_up();
        t_down();
        t_start();
        t_disp();
        t_busy();
        t_cs();
        t_unused();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule